// File: doc/BRIEF.md
# Debug Instruction Injection Sequencer

This block sits on the debugger side of a processor core's halt-mode debug port and runs one complete debug transaction. The host starts it, and it takes over from there. It asks the core to stop and waits until the core says it has stopped. It then loads the host's value into the core's data0 scratch register and feeds a short program to the core, one 32-bit instruction word at a time, over a valid/ready handshake. While halted, the core executes only words supplied this way.

The host fills a small program buffer and gives a word count before it raises `start`. The sequencer adds an ebreak (0x00100073) after the host's last word. The core reports one of two outcomes with a one-cycle pulse: a caught ebreak, which means the program finished, or a caught exception, which means it failed. On success the sequencer copies data0 back into a result register. On a failure, or when no pulse arrives within a programmable number of cycles, it sets an error flag and skips that copy. In every case it then sends a one-cycle resume request and waits for the core to report that it is running again.

A typical program is `csrr a0, data0` (0x7b202573), some arithmetic on a0, then `csrw data0, a0` (0x7b251073). Such a program gives the host a computed value through the data0 register at address 0x7b2.

Top module: `dbg_inject_seq`

## Requirements
- R1: `start` is acted on only while `busy` is low. `busy` rises in the cycle after an accepted `start` and stays high until `core_running` has been seen in the final step. `done` is then high for exactly one cycle, and it is high in the same cycle that `busy` is low again.
- R2: `halt_req` stays high until `core_halted` is sampled high, and it is low in the next cycle.
- R3: After the halt, `d0_wen` is high for exactly one cycle with `d0_wdata` equal to the `data0_init` value captured at start.
- R4: Program words 0 to count-1 are presented in buffer order on `instr_word` with `instr_vld` high. A word is held until a cycle where `instr_rdy` is high, and only then does the next word appear. A `prog_count` above the buffer depth (8) is treated as 8.
- R5: After the last program word, the word 0x00100073 (ebreak) is presented. `instr_vld` drops once it has been accepted. A count of 0 injects only this word.
- R6: A `caught_ebreak` pulse during injection or while waiting ends the program successfully. `d0_rdata` is then copied into `data0_result`, and `error` stays low.
- R7: A `caught_exc` pulse during injection or while waiting sets `error` and leaves `data0_result` unchanged. The resume step still follows.
- R8: If neither pulse arrives within `timeout_cycles` cycles after injection begins, `error` is set, `data0_result` is left unchanged, and the resume step still follows.
- R9: `resume_req` is a single one-cycle pulse per transaction.
- R10: Writes to the program buffer and `start` pulses made while `busy` is high have no effect.
- R11: `error` holds its value after `done` and is cleared when the next `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start | input | 1 | Starts a transaction (used only when idle) |
| prog_we | input | 1 | Program buffer write strobe |
| prog_waddr | input | 3 | Program buffer slot |
| prog_wdata | input | 32 | Instruction word to store |
| prog_count | input | 4 | Number of program words to inject |
| data0_init | input | 32 | Value loaded into data0 before injection |
| timeout_cycles | input | 12 | Cycles allowed for a caught pulse |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| error | output | 1 | Last transaction faulted or timed out |
| data0_result | output | 32 | data0 read back after a successful program |
| halt_req | output | 1 | Halt request to the core |
| core_halted | input | 1 | Core reports halted |
| d0_wen | output | 1 | data0 write enable |
| d0_wdata | output | 32 | data0 write value |
| d0_rdata | input | 32 | data0 read value |
| instr_vld | output | 1 | Injected word valid |
| instr_word | output | 32 | Injected instruction word |
| instr_rdy | input | 1 | Core accepts the injected word |
| caught_ebreak | input | 1 | Core caught an ebreak while in debug mode |
| caught_exc | input | 1 | Core caught any other exception while in debug mode |
| resume_req | output | 1 | Resume request pulse |
| core_running | input | 1 | Core reports running |

## Verification
The bench uses the default parameters: an 8-entry program buffer, a 4-bit count and a 12-bit timeout counter. It drives the block with a small behavioural core that actually executes the data0 transfers and the a0 additions, so each result value is an arithmetic outcome the bench works out for itself. With 8 entries, a full program and a count above the buffer depth can both be run. A 12-bit timeout can be set short at run time, so the no-response case ends quickly. The ready line can be set to stay high or to toggle, so valid-hold stalls are covered.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;

  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HALT   = 3'd1,
    ST_LOAD   = 3'd2,
    ST_INJECT = 3'd3,
    ST_WAIT   = 3'd4,
    ST_READ   = 3'd5,
    ST_RESUME = 3'd6,
    ST_RUN    = 3'd7
  } seq_state_e;

endpackage

// File: rtl/dbg_prog_buf.sv
module dbg_prog_buf #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] slot_vals [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              slot_en;
    logic [WORD_W-1:0] slot_q;

    assign slot_en = wr_en && (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= wr_data;
      end
    end

    assign slot_vals[g] = slot_q;
  end

  assign rd_data = slot_vals[rd_addr];

endmodule

// File: rtl/dbg_trap_timer.sv
module dbg_trap_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr || (run && (cnt_q != '1));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && (cnt_q >= limit);

endmodule

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_inject_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CW     = 4,
  parameter int AW     = 3,
  parameter int TMO_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     count_in,
  input  logic [WORD_W-1:0] init_in,
  input  logic [TMO_W-1:0]  tmo_in,
  input  logic              core_halted,
  input  logic              core_running,
  input  logic              instr_rdy,
  input  logic              caught_ebreak,
  input  logic              caught_exc,
  input  logic [WORD_W-1:0] d0_rdata,
  input  logic              tmr_expired,
  input  logic [WORD_W-1:0] buf_rd_data,
  output logic [AW-1:0]     buf_rd_addr,
  output logic              tmr_clr,
  output logic              tmr_run,
  output logic [TMO_W-1:0]  tmr_limit,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [WORD_W-1:0] data0_result,
  output logic              halt_req,
  output logic              d0_wen,
  output logic [WORD_W-1:0] d0_wdata,
  output logic              instr_vld,
  output logic [WORD_W-1:0] instr_word,
  output logic              resume_req
);

  seq_state_e        state_q, state_d;
  logic [CW-1:0]     idx_q, idx_d;
  logic              idx_en;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] init_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              err_q, err_d, err_en;
  logic [WORD_W-1:0] res_q;
  logic              res_en;
  logic              done_q, done_d;
  logic              start_acc;
  logic              last_word;
  logic              trap_phase;
  logic              abort;

  assign start_acc  = start && (state_q == ST_IDLE);
  assign last_word  = (idx_q == cnt_q);
  assign trap_phase = (state_q == ST_INJECT) || (state_q == ST_WAIT);
  assign abort      = trap_phase && (caught_exc || (tmr_expired && !caught_ebreak));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    err_d   = err_q;
    err_en  = 1'b0;
    res_en  = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_HALT;
          err_d   = 1'b0;
          err_en  = 1'b1;
        end
      end
      ST_HALT: begin
        if (core_halted) begin
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        state_d = ST_INJECT;
        idx_d   = '0;
        idx_en  = 1'b1;
      end
      ST_INJECT: begin
        if (abort) begin
          state_d = ST_RESUME;
          err_d   = 1'b1;
          err_en  = 1'b1;
        end else if (caught_ebreak) begin
          state_d = ST_READ;
        end else if (instr_rdy) begin
          if (last_word) begin
            state_d = ST_WAIT;
          end else begin
            idx_d  = idx_q + 1'b1;
            idx_en = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (abort) begin
          state_d = ST_RESUME;
          err_d   = 1'b1;
          err_en  = 1'b1;
        end else if (caught_ebreak) begin
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        state_d = ST_RESUME;
        res_en  = 1'b1;
      end
      ST_RESUME: begin
        state_d = ST_RUN;
      end
      ST_RUN: begin
        if (core_running) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      init_q <= '0;
      tmo_q  <= '0;
    end else if (start_acc) begin
      cnt_q  <= count_in;
      init_q <= init_in;
      tmo_q  <= tmo_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= d0_rdata;
    end
  end

  assign buf_rd_addr  = idx_q[AW-1:0];
  assign tmr_clr      = (state_q == ST_LOAD);
  assign tmr_run      = trap_phase;
  assign tmr_limit    = tmo_q;
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign error        = err_q;
  assign data0_result = res_q;
  assign halt_req     = (state_q == ST_HALT);
  assign d0_wen       = (state_q == ST_LOAD);
  assign d0_wdata     = init_q;
  assign instr_vld    = (state_q == ST_INJECT);
  assign instr_word   = last_word ? INSN_EBREAK : buf_rd_data;
  assign resume_req   = (state_q == ST_RESUME);

endmodule

// File: rtl/dbg_inject_seq.sv
module dbg_inject_seq #(
  parameter int PROG_DEPTH = 8,
  parameter int WORD_W     = 32,
  parameter int TMO_W      = 12,
  localparam int AW        = $clog2(PROG_DEPTH),
  localparam int CW        = $clog2(PROG_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              prog_we,
  input  logic [AW-1:0]     prog_waddr,
  input  logic [WORD_W-1:0] prog_wdata,
  input  logic [CW-1:0]     prog_count,
  input  logic [WORD_W-1:0] data0_init,
  input  logic [TMO_W-1:0]  timeout_cycles,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [WORD_W-1:0] data0_result,
  output logic              halt_req,
  input  logic              core_halted,
  output logic              d0_wen,
  output logic [WORD_W-1:0] d0_wdata,
  input  logic [WORD_W-1:0] d0_rdata,
  output logic              instr_vld,
  output logic [WORD_W-1:0] instr_word,
  input  logic              instr_rdy,
  input  logic              caught_ebreak,
  input  logic              caught_exc,
  output logic              resume_req,
  input  logic              core_running
);

  logic              rst_meta_q;
  logic              rst_sync_q;
  logic [CW-1:0]     count_clamped;
  logic              buf_we;
  logic [AW-1:0]     buf_rd_addr;
  logic [WORD_W-1:0] buf_rd_data;
  logic              tmr_clr;
  logic              tmr_run;
  logic [TMO_W-1:0]  tmr_limit;
  logic              tmr_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign count_clamped = (prog_count > CW'(PROG_DEPTH)) ? CW'(PROG_DEPTH) : prog_count;
  assign buf_we        = prog_we && !busy;

  dbg_prog_buf #(
    .DEPTH  (PROG_DEPTH),
    .WORD_W (WORD_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (buf_we),
    .wr_addr (prog_waddr),
    .wr_data (prog_wdata),
    .rd_addr (buf_rd_addr),
    .rd_data (buf_rd_data)
  );

  dbg_trap_timer #(
    .CNT_W (TMO_W)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .clr     (tmr_clr),
    .run     (tmr_run),
    .limit   (tmr_limit),
    .expired (tmr_expired)
  );

  dbg_seq_ctrl #(
    .WORD_W (WORD_W),
    .CW     (CW),
    .AW     (AW),
    .TMO_W  (TMO_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .start         (start),
    .count_in      (count_clamped),
    .init_in       (data0_init),
    .tmo_in        (timeout_cycles),
    .core_halted   (core_halted),
    .core_running  (core_running),
    .instr_rdy     (instr_rdy),
    .caught_ebreak (caught_ebreak),
    .caught_exc    (caught_exc),
    .d0_rdata      (d0_rdata),
    .tmr_expired   (tmr_expired),
    .buf_rd_data   (buf_rd_data),
    .buf_rd_addr   (buf_rd_addr),
    .tmr_clr       (tmr_clr),
    .tmr_run       (tmr_run),
    .tmr_limit     (tmr_limit),
    .busy          (busy),
    .done          (done),
    .error         (error),
    .data0_result  (data0_result),
    .halt_req      (halt_req),
    .d0_wen        (d0_wen),
    .d0_wdata      (d0_wdata),
    .instr_vld     (instr_vld),
    .instr_word    (instr_word),
    .resume_req    (resume_req)
  );

endmodule

// File: rtl/dbg_inject_seq_chk.sv
module dbg_inject_seq_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              halt_req,
  input logic              core_halted,
  input logic              d0_wen,
  input logic              instr_vld,
  input logic [WORD_W-1:0] instr_word,
  input logic              instr_rdy,
  input logic              resume_req
);

  // R1: done is a single cycle and coincides with busy low
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r1_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2: halt request dropped the cycle after halted is seen
  a_r2_halt_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && core_halted) |=> !halt_req);

  // R3: data0 write enable lasts one cycle
  a_r3_wen_single: assert property (@(posedge clk) disable iff (!rst_n)
    d0_wen |=> !d0_wen);

  // R4: a stalled word stays valid and unchanged
  a_r4_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld && !instr_rdy) |=> (instr_vld && $stable(instr_word)));

  // R9: resume request is a one-cycle pulse, never together with halt
  a_r9_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |=> !resume_req);
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(resume_req && halt_req));

  // R10: nothing is driven to the core while idle
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!instr_vld && !halt_req && !d0_wen && !resume_req));

endmodule

bind dbg_inject_seq dbg_inject_seq_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/dbg_inject_seq_tb_top.sv
module dbg_inject_seq_tb_top;

  localparam logic [31:0] EBRK = 32'h0010_0073;
  localparam logic [31:0] CSRR = 32'h7b20_2573;
  localparam logic [31:0] CSRW = 32'h7b25_1073;
  localparam int NVEC = 6;
  // {init[15:0], nadd[3:0], imm[11:0], 5'b0, fault, mute, rdy_toggle}
  localparam logic [39:0] VECS [NVEC] = '{
    {16'd123,  4'd1, 12'd456,  5'd0, 3'b000},
    {16'd1000, 4'd6, 12'hff9,  5'd0, 3'b001},
    {16'd5,    4'd0, 12'd0,    5'd0, 3'b001},
    {16'd77,   4'd2, 12'd3,    5'd0, 3'b100},
    {16'd9,    4'd1, 12'd1,    5'd0, 3'b010},
    {16'd300,  4'd3, 12'd100,  5'd0, 3'b001}
  };

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        prog_we;
  logic [2:0]  prog_waddr;
  logic [31:0] prog_wdata;
  logic [3:0]  prog_count;
  logic [31:0] data0_init;
  logic [11:0] timeout_cycles;
  logic        busy, done, error;
  logic [31:0] data0_result;
  logic        halt_req, core_halted;
  logic        d0_wen;
  logic [31:0] d0_wdata, d0_rdata;
  logic        instr_vld, instr_rdy;
  logic [31:0] instr_word;
  logic        caught_ebreak, caught_exc;
  logic        resume_req, core_running;

  logic        mute;
  logic        rdy_mode;

  int total;
  int bad;

  dbg_inject_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .prog_we(prog_we),
    .prog_waddr(prog_waddr), .prog_wdata(prog_wdata), .prog_count(prog_count),
    .data0_init(data0_init), .timeout_cycles(timeout_cycles),
    .busy(busy), .done(done), .error(error), .data0_result(data0_result),
    .halt_req(halt_req), .core_halted(core_halted), .d0_wen(d0_wen),
    .d0_wdata(d0_wdata), .d0_rdata(d0_rdata), .instr_vld(instr_vld),
    .instr_word(instr_word), .instr_rdy(instr_rdy),
    .caught_ebreak(caught_ebreak), .caught_exc(caught_exc),
    .resume_req(resume_req), .core_running(core_running)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural core model
  logic        hstage, rstage, rdy_tgl, p_eb, p_ex, accept;
  logic [31:0] d0_reg, a0;
  int          acc_total, wen_total, res_total, hov_total;
  logic [31:0] last_word;

  assign accept    = instr_vld && instr_rdy && core_halted;
  assign instr_rdy = rdy_mode ? rdy_tgl : 1'b1;
  assign d0_rdata  = d0_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hstage <= 1'b0; rstage <= 1'b0; rdy_tgl <= 1'b0;
      core_halted <= 1'b0; core_running <= 1'b1;
      p_eb <= 1'b0; p_ex <= 1'b0; caught_ebreak <= 1'b0; caught_exc <= 1'b0;
      d0_reg <= '0; a0 <= '0; last_word <= '0;
      acc_total <= 0; wen_total <= 0; res_total <= 0; hov_total <= 0;
    end else begin
      rdy_tgl <= ~rdy_tgl;
      hstage  <= halt_req && !core_halted;
      if (hstage) begin core_halted <= 1'b1; core_running <= 1'b0; end
      rstage <= resume_req;
      if (rstage) begin core_halted <= 1'b0; core_running <= 1'b1; end
      if (d0_wen) wen_total <= wen_total + 1;
      if (resume_req) res_total <= res_total + 1;
      if (halt_req && core_halted) hov_total <= hov_total + 1;
      caught_ebreak <= p_eb && !p_ex;
      caught_exc    <= p_ex;
      p_eb <= accept && (instr_word == EBRK) && !mute && !p_ex;
      p_ex <= accept && (instr_word == 32'h0) && !mute;
      if (d0_wen) d0_reg <= d0_wdata;
      if (accept) begin
        acc_total <= acc_total + 1;
        last_word <= instr_word;
        if (instr_word == CSRR) a0 <= d0_reg;
        if (instr_word == CSRW) d0_reg <= a0;
        if (instr_word[6:0] == 7'h13 && instr_word[11:7] == 5'd10 &&
            instr_word[19:15] == 5'd10 && instr_word[14:12] == 3'd0)
          a0 <= a0 + {{20{instr_word[31]}}, instr_word[31:20]};
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_waddr = 3'(a); prog_wdata = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  function automatic logic [31:0] addi(input logic [11:0] imm);
    return {imm, 5'd10, 3'd0, 5'd10, 7'h13};
  endfunction

  // Runs one transaction; poke writes the buffer and re-pulses start mid-run
  task automatic run_seq(input bit poke);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", 32'(busy), 32'd1);
    for (int i = 0; i < 4000; i++) begin
      if (done) break;
      if (poke && i == 3) begin
        start = 1'b1; prog_we = 1'b1; prog_waddr = 3'd1; prog_wdata = addi(12'd1000);
      end else begin
        start = 1'b0; prog_we = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; prog_we = 1'b0;
    chk("R1 done seen", 32'(done), 32'd1);
    chk("R1 busy low at done", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a_s, w_s, r_s, h_s;
    logic [31:0] prev_res;
    total = 0; bad = 0;
    rst_n = 1'b0; start = 1'b0; prog_we = 1'b0; prog_waddr = '0; prog_wdata = '0;
    prog_count = '0; data0_init = '0; timeout_cycles = 12'd400; mute = 1'b0; rdy_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", 32'(busy), 32'd0);
    chk("R1 reset done", 32'(done), 32'd0);
    chk("R11 reset error", 32'(error), 32'd0);
    chk("R2 reset halt_req", 32'(halt_req), 32'd0);
    chk("R4 reset instr_vld", 32'(instr_vld), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    prev_res = 32'd0;

    for (int v = 0; v < NVEC; v++) begin
      logic [39:0] e;
      int nadd, cnt;
      logic [31:0] imm_s, exp_res;
      bit fault, mt, rt, err_exp;
      e = VECS[v];
      nadd = int'(e[23:20]);
      imm_s = {{20{e[19]}}, e[19:8]};
      fault = e[2]; mt = e[1]; rt = e[0];
      err_exp = fault || mt;
      put_word(0, CSRR);
      for (int k = 1; k <= nadd; k++) put_word(k, addi(e[19:8]));
      put_word(nadd + 1, fault ? 32'h0 : CSRW);
      cnt = nadd + 2;
      prog_count = 4'(cnt);
      data0_init = {16'd0, e[39:24]};
      timeout_cycles = mt ? 12'd30 : 12'd400;
      mute = mt; rdy_mode = rt;
      a_s = acc_total; w_s = wen_total; r_s = res_total; h_s = hov_total;
      run_seq(1'b0);
      exp_res = err_exp ? prev_res : (data0_init + 32'(nadd) * imm_s);
      prev_res = exp_res;
      chk(fault ? "R7 error on exception" : (mt ? "R8 error on timeout" : "R11 error clear"),
          32'(error), 32'(err_exp));
      chk(err_exp ? "R7 result kept" : "R6 readback", data0_result, exp_res);
      chk("R3 one data0 write", 32'(wen_total - w_s), 32'd1);
      chk("R9 one resume", 32'(res_total - r_s), 32'd1);
      chk("R2 halt drop", 32'(hov_total - h_s), 32'd1);
      if (!fault) begin
        chk("R4 word count", 32'(acc_total - a_s), 32'(cnt + 1));
        chk("R5 ebreak last", last_word, EBRK);
      end
      @(negedge clk);
      chk("R1 done one cycle", 32'(done), 32'd0);
      chk("R11 error held", 32'(error), 32'(err_exp));
    end

    // R5: empty program injects only ebreak; data0 keeps the loaded value
    mute = 1'b0; rdy_mode = 1'b0; prog_count = 4'd0; data0_init = 32'd4242;
    timeout_cycles = 12'd400;
    a_s = acc_total;
    run_seq(1'b0);
    chk("R5 only ebreak", 32'(acc_total - a_s), 32'd1);
    chk("R5 empty result", data0_result, 32'd4242);

    // R4: count above depth clamps to 8
    put_word(0, CSRR);
    for (int k = 1; k <= 6; k++) put_word(k, addi(12'd2));
    put_word(7, CSRW);
    prog_count = 4'd12; data0_init = 32'd50; rdy_mode = 1'b1;
    a_s = acc_total;
    run_seq(1'b0);
    chk("R4 clamp count", 32'(acc_total - a_s), 32'd9);
    chk("R4 clamp result", data0_result, 32'd62);

    // R10: writes and start while busy ignored
    put_word(0, CSRR);
    put_word(1, addi(12'd10));
    put_word(2, CSRW);
    prog_count = 4'd3; data0_init = 32'd1; rdy_mode = 1'b0;
    run_seq(1'b1);
    chk("R10 result first", data0_result, 32'd11);
    repeat (5) @(negedge clk);
    chk("R10 no restart", 32'(busy), 32'd0);
    data0_init = 32'd2;
    run_seq(1'b0);
    chk("R10 buffer unchanged", data0_result, 32'd12);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule